// File: doc/BRIEF.md
# Banked Synchronous SRAM Read-Drive Controller

This block sits on the data side of a synchronous SRAM with a registered, pipelined read path. A fixed strobe per access starts each operation, but only while three chip selects are all active: an active-low enable, an active-high select and an active-low select. Each access is either a read or a masked byte write. The address and command are captured on one rising edge. The read word is registered on the next edge, so it is present for exactly one cycle and is then dropped. A small behavioural register file stands in for the storage array.

The block decides when the data bus may be driven. Drive requires four things at once: the asynchronous output enable is low, a registered select-history bit says the part was selected on two consecutive edges, no write is being committed, and a registered read word is present. This history bit lets two copies share one bus as alternating banks without contention. When the selects are tied active the history bit is always set, so the drive adds no delay.

The read result is a stream with a valid flag and no ready. There is no back-pressure: a consumer must take the word in the one cycle that `rd_valid` is high, because the next edge replaces or drops it.

Top module: `sram_rd_oe_ctl`

## Requirements
- R1: An access is accepted on a rising edge only when `ce_n`=0, `cs0`=1, `cs1_n`=0 and `ads_n`=0. Any other select combination produces no read and no write.
- R2: A read accepted on edge k sets `rd_valid` and presents the word at `rd_addr` on `rd_data` after edge k+1. `rd_data` keeps that value until a later read result replaces it.
- R3: `oe_n`=1 forces `dq_drive` low at once, with no clock edge needed. Returning `oe_n` to 0 restores drive within the same cycle.
- R4: The read result of an access accepted on edge k is driven only if the part was also selected on edge k-1. With the selects held active, drive coincides with `rd_valid`, with no extra cycle.
- R5: With `gw_n`=0 all four bytes are written. Otherwise, with `bwe_n`=0, byte i (`wdata[8i+7:8i]`) is written where `bw_n[i]`=0. With `bwe_n`=1 the `bw_n` bits have no effect, and an access with no byte enabled is a read.
- R6: A write accepted on edge k forces `dq_drive` low for the cycle after edge k, even while an earlier read result is valid.
- R7: If no access is accepted on edge k, `rd_valid` is low after edge k+1. Deselect takes effect within a single cycle.
- R8: `dq_out` equals `rd_data` while `dq_drive` is high and is zero otherwise.
- R9: Two instances whose selects are never active together never assert `dq_drive` in the same cycle.
- R10: During reset `rd_valid` and `dq_drive` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| cs0 | input | 1 | Active-high chip select |
| cs1_n | input | 1 | Active-low chip select |
| ads_n | input | 1 | Active-low access strobe |
| rd_addr | input | AW | Word address of the access |
| gw_n | input | 1 | Active-low write of all bytes |
| bwe_n | input | 1 | Active-low gate for the per-byte enables |
| bw_n | input | DW/8 | Active-low per-byte write enables |
| wdata | input | DW | Write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rd_data | output | DW | Registered read word |
| rd_valid | output | 1 | Read word present this cycle |
| dq_drive | output | 1 | Bus drive enable |
| dq_out | output | DW | Value to place on the shared bus |

## Verification
The assertions check four things on every cycle: a deselected edge is never followed by read data or drive two cycles later, a write edge always mutes the next cycle's drive, and a pipeline read is always followed by a valid, held result. Only the bench's scenarios can show the rest. These are the stored contents under every byte-mask pattern and every select combination, the asynchronous reaction to the output enable, and two banks switching every cycle or every two cycles while drive never overlaps and each drive matches a history model kept in the bench.

// File: rtl/sram_oc_pkg.sv
package sram_oc_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_sel_dly.sv
module sram_sel_dly (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cs0,
  input  logic cs1_n,
  output logic sel_raw,
  output logic en_dly
);
  logic sel_q;
  logic sel_q2;

  assign sel_raw = !ce_n && cs0 && !cs1_n;

  // en_dly after edge k+1 reflects selection on edges k and k-1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      sel_q2 <= 1'b0;
      en_dly <= 1'b0;
    end else begin
      sel_q  <= sel_raw;
      sel_q2 <= sel_q;
      en_dly <= sel_q && sel_q2;
    end
  end
endmodule

// File: rtl/sram_cmd_stage.sv
module sram_cmd_stage
  import sram_oc_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_raw,
  input  logic          ads_n,
  input  logic [AW-1:0] rd_addr,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  input  logic [DW-1:0] wdata,
  output op_e           op_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [NB-1:0] bmask_q
);
  logic [NB-1:0] bmask;
  op_e           op;

  always_comb begin
    if (!gw_n)       bmask = '1;
    else if (!bwe_n) bmask = ~bw_n;
    else             bmask = '0;
    if (!(sel_raw && !ads_n)) op = OP_NONE;
    else if (|bmask)          op = OP_WRITE;
    else                      op = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
      bmask_q <= '0;
    end else begin
      op_q    <= op;
      addr_q  <= rd_addr;
      wdata_q <= wdata;
      bmask_q <= bmask;
    end
  end
endmodule

// File: rtl/sram_store.sv
module sram_store
  import sram_oc_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int NB    = DW / 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op_q,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic [NB-1:0] bmask_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] rd_word;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (op_q == OP_WRITE && bmask_q[b]) lane[addr_q] <= wdata_q[b*8 +: 8];
    end
    assign rd_word[b*8 +: 8] = lane[addr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= (op_q == OP_READ);
      if (op_q == OP_READ) rd_data <= rd_word;
    end
  end

  // R2: a pipeline read always yields a valid result on the next edge
  assert_read_yields_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_READ) |=> rd_valid);

  // R2: the result register holds when no read is in the pipeline
  assert_result_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_READ) |=> $stable(rd_data));
endmodule

// File: rtl/sram_rd_oe_ctl.sv
module sram_rd_oe_ctl
  import sram_oc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          cs0,
  input  logic          cs1_n,
  input  logic          ads_n,
  input  logic [AW-1:0] rd_addr,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  input  logic [DW-1:0] wdata,
  input  logic          oe_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          dq_drive,
  output logic [DW-1:0] dq_out
);
  logic          sel_raw;
  logic          en_dly;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] bmask_q;
  logic          wr_busy;

  sram_sel_dly u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .cs0    (cs0),
    .cs1_n  (cs1_n),
    .sel_raw(sel_raw),
    .en_dly (en_dly)
  );

  sram_cmd_stage #(.AW(AW), .DW(DW)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_raw(sel_raw),
    .ads_n  (ads_n),
    .rd_addr(rd_addr),
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .bw_n   (bw_n),
    .wdata  (wdata),
    .op_q   (op_q),
    .addr_q (addr_q),
    .wdata_q(wdata_q),
    .bmask_q(bmask_q)
  );

  sram_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_q    (op_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .bmask_q (bmask_q),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  assign wr_busy  = (op_q == OP_WRITE);
  assign dq_drive = !oe_n && en_dly && rd_valid && !wr_busy;
  assign dq_out   = dq_drive ? rd_data : '0;

  // R7: an edge without an accepted access gives no read data one cycle later
  assert_deselect_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_raw && !ads_n) |=> ##1 !rd_valid);

  // R4: a deselected edge blocks drive of the following edge's read result
  assert_switch_holds_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_raw |=> ##2 !dq_drive);

  // R6: an accepted write mutes the bus in the next cycle
  assert_write_mutes_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_raw && !ads_n && (!gw_n || (!bwe_n && !(&bw_n)))) |=> !dq_drive);
endmodule

// File: tb/test_sram_rd_oe_ctl.sv
`timescale 1ns/1ps
module test_sram_rd_oe_ctl;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NB = DW / 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, cs0_a, cs0_b, cs1_n, ads_n, gw_n, bwe_n, oe_n;
  logic [AW-1:0] rd_addr;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rd_data_a, rd_data_b, dq_out_a, dq_out_b;
  logic rd_valid_a, rd_valid_b, drive_a, drive_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DW-1:0] exp_a [16];

  always #4 clk = ~clk;

  sram_rd_oe_ctl #(.DW(DW), .AW(AW)) i_sram_rd_oe_ctl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs0(cs0_a), .cs1_n(cs1_n),
    .ads_n(ads_n), .rd_addr(rd_addr), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .wdata(wdata), .oe_n(oe_n), .rd_data(rd_data_a), .rd_valid(rd_valid_a),
    .dq_drive(drive_a), .dq_out(dq_out_a));

  sram_rd_oe_ctl #(.DW(DW), .AW(AW)) i_sram_rd_oe_ctl_b (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs0(cs0_b), .cs1_n(cs1_n),
    .ads_n(ads_n), .rd_addr(rd_addr), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .wdata(wdata), .oe_n(oe_n), .rd_data(rd_data_b), .rd_valid(rd_valid_b),
    .dq_drive(drive_b), .dq_out(dq_out_b));

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hA500_0000 ^ (32'(a) * 32'h0103_0507);
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic read_sweep_a;
    for (int a = 0; a <= 16; a++) begin
      if (a < 16) begin rd_addr = AW'(a); ads_n = 1'b0; end
      else ads_n = 1'b1;
      step;
      if (a > 0) begin
        check(rd_valid_a === 1'b1, "R2 valid", 32'(rd_valid_a), 1);
        check(rd_data_a === exp_a[a-1], "R2/R5 data", rd_data_a, exp_a[a-1]);
        check(drive_a === 1'b1, "R4 no delay tied active", 32'(drive_a), 1);
        check(dq_out_a === exp_a[a-1], "R8 bus value", dq_out_a, exp_a[a-1]);
      end
    end
    step;
    check(rd_valid_a === 1'b0, "R7 idle drops valid", 32'(rd_valid_a), 0);
    check(rd_data_a === exp_a[15], "R2 hold", rd_data_a, exp_a[15]);
    check(dq_out_a === 32'h0, "R8 zero when idle", dq_out_a, 0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] wd;
    bit pa_sel, pa_rd, pa_sel2, pb_sel, pb_rd, pb_sel2, ea, eb;
    int pa_addr;
    rst_n = 1'b0; ce_n = 1'b1; cs0_a = 1'b0; cs0_b = 1'b0; cs1_n = 1'b0;
    ads_n = 1'b1; rd_addr = '0; gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    wdata = '0; oe_n = 1'b0;
    repeat (3) step;
    check(rd_valid_a === 1'b0, "R10 valid in reset", 32'(rd_valid_a), 0);
    check(drive_a === 1'b0 && drive_b === 1'b0, "R10 drive in reset", 32'(drive_a), 0);
    rst_n = 1'b1;
    ce_n = 1'b0; cs0_a = 1'b1;
    step;

    // R5 full-word writes, R6 bus muted after each write
    for (int a = 0; a < 16; a++) begin
      rd_addr = AW'(a); ads_n = 1'b0; gw_n = 1'b0; wdata = pat(a); exp_a[a] = pat(a);
      step;
      check(drive_a === 1'b0, "R6 write mutes", 32'(drive_a), 0);
    end
    ads_n = 1'b1; gw_n = 1'b1;
    step;
    read_sweep_a;

    // R5 every byte-mask pattern
    for (int m = 0; m < 16; m++) begin
      rd_addr = AW'(m); ads_n = 1'b0; bwe_n = 1'b0; bw_n = ~NB'(m);
      wd = ~pat(m) ^ 32'h5A5A_5A5A; wdata = wd;
      for (int b = 0; b < NB; b++)
        if (m[b]) exp_a[m][b*8 +: 8] = wd[b*8 +: 8];
      step;
    end
    ads_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    step;
    read_sweep_a;

    // R5 byte enables ignored without bwe_n
    rd_addr = 4'd5; ads_n = 1'b0; bw_n = '0; wdata = '0;
    step;
    ads_n = 1'b1; bw_n = '1;
    step;
    check(rd_valid_a === 1'b1, "R5 gated enables give read", 32'(rd_valid_a), 1);
    check(rd_data_a === exp_a[5], "R5 no write without bwe_n", rd_data_a, exp_a[5]);

    // R3 asynchronous output enable
    rd_addr = 4'd3; ads_n = 1'b0;
    step;
    ads_n = 1'b1; oe_n = 1'b1;
    step;
    check(rd_valid_a === 1'b1, "R3 valid kept", 32'(rd_valid_a), 1);
    check(drive_a === 1'b0, "R3 oe_n high blocks", 32'(drive_a), 0);
    check(dq_out_a === 32'h0, "R8 zero when off", dq_out_a, 0);
    oe_n = 1'b0;
    #1;
    check(drive_a === 1'b1, "R3 oe_n low restores", 32'(drive_a), 1);
    check(dq_out_a === exp_a[3], "R8 bus value", dq_out_a, exp_a[3]);

    // R6 write right after a read
    rd_addr = 4'd2; ads_n = 1'b0;
    step;
    rd_addr = 4'd9; gw_n = 1'b0; wdata = 32'hDEAD_BEEF; exp_a[9] = 32'hDEAD_BEEF;
    step;
    check(rd_valid_a === 1'b1, "R6 read result present", 32'(rd_valid_a), 1);
    check(drive_a === 1'b0, "R6 write overrides drive", 32'(drive_a), 0);
    gw_n = 1'b1; ads_n = 1'b1;
    step;

    // R1 every select combination
    for (int c = 0; c < 8; c++) begin
      ce_n = c[2]; cs0_a = c[1]; cs1_n = c[0]; ads_n = 1'b0; rd_addr = AW'(c);
      step;
      ce_n = 1'b0; cs0_a = 1'b1; cs1_n = 1'b0; ads_n = 1'b1;
      step;
      check(rd_valid_a === (c == 2), $sformatf("R1 select combo %0d", c),
            32'(rd_valid_a), 32'(c == 2));
      if (c == 2) check(rd_data_a === exp_a[2], "R1 data", rd_data_a, exp_a[2]);
    end

    // R4 first read after reselect is not driven
    ce_n = 1'b1;
    step;
    ce_n = 1'b0; rd_addr = 4'd1; ads_n = 1'b0;
    step;
    ads_n = 1'b1;
    step;
    check(rd_valid_a === 1'b1, "R4 data valid", 32'(rd_valid_a), 1);
    check(drive_a === 1'b0, "R4 held off after reselect", 32'(drive_a), 0);

    // load bank B
    cs0_a = 1'b0; cs0_b = 1'b1;
    step;
    for (int a = 0; a < 4; a++) begin
      rd_addr = AW'(a); ads_n = 1'b0; gw_n = 1'b0; wdata = pat(a) ^ 32'hFFFF_0000;
      step;
    end
    gw_n = 1'b1; ads_n = 1'b1;
    step;

    // R9/R4 alternating banks
    pa_sel = 0; pa_rd = 0; pa_sel2 = 0; pb_sel = 1; pb_rd = 0; pb_sel2 = 1; pa_addr = 0;
    for (int i = 0; i < 72; i++) begin
      int bank;
      bank = (i < 36) ? ((i / 2) % 3) : (i % 2);
      if (i == 71) bank = 2;
      cs0_a = (bank == 0); cs0_b = (bank == 1); ads_n = 1'b0; rd_addr = AW'(i % 4);
      ea = pa_rd && pa_sel2;
      eb = pb_rd && pb_sel2;
      step;
      check(!(drive_a && drive_b), "R9 no overlap", {drive_a, drive_b}, 0);
      check(drive_a === ea, "R4 bank A drive", 32'(drive_a), 32'(ea));
      check(drive_b === eb, "R4 bank B drive", 32'(drive_b), 32'(eb));
      if (ea) check(dq_out_a === exp_a[pa_addr], "R8 bank A data", dq_out_a, exp_a[pa_addr]);
      if (eb) check(dq_out_b === (pat(pa_addr) ^ 32'hFFFF_0000), "R8 bank B data",
                    dq_out_b, pat(pa_addr) ^ 32'hFFFF_0000);
      pa_sel2 = pa_sel; pa_sel = (bank == 0); pa_rd = (bank == 0);
      pb_sel2 = pb_sel; pb_sel = (bank == 1); pb_rd = (bank == 1);
      pa_addr = i % 4;
    end
    ads_n = 1'b1;
    step;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule